// File: doc/BRIEF.md
# NAND Page Single-Bit ECC Corrector

This block checks one 512-byte chunk of a NAND page against a 24-bit row/column parity code. It takes two 24-bit codes. One is the code kept in the page's spare area. The other is the code the read path computed over the data just fetched. Each code is packed with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. The syndrome is the XOR of the two codes. The block sorts it into one of four outcomes:

- clean data
- a correctable single-bit data error
- a fault in the stored code only, where the data is still good
- an uncorrectable error

A stored code of all ones marks a page that was never written with a code. Such a page counts as clean.

For a correctable error the block reports which byte is wrong and which bit to flip. If the caller asked for a repair, it then reads that byte from a byte-wide data RAM and writes it back with the bit inverted.

Requests enter through a valid/ready handshake. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The caller may hold `in_valid` high while `in_ready` is low; the request waits and its inputs must stay stable. The result is a one-cycle `res_valid` pulse with no back-pressure, so the consumer must take it in that cycle. The RAM port has no handshake. It assumes a RAM with one cycle of read latency.

Top module: `nand_ecc_fixer`

## Requirements
- R1: When stored and computed codes are equal, the result status is 2'b00 (clean), and the byte index and bit mask are zero. The byte index and bit mask are zero for every status other than 2'b01.
- R2: When the stored code is 24'hFFFFFF, the status is 2'b00 whatever the computed code is, and the RAM is not touched.
- R3: The syndrome is correctable when, in each of its three bytes, bits 1:0, 3:2, 5:4 and 7:6 each hold two different values. A correctable syndrome gives status 2'b01. The byte index is built from these syndrome bits:
  - bits 3:0 from byte 0 bits 7,5,3,1
  - bits 7:4 from byte 1 bits 7,5,3,1
  - bit 8 from byte 2 bit 1

  The bit mask is one-hot at the position whose bits 2:0 come from byte 2 bits 7,5,3.
- R4: A syndrome with exactly one bit set gives status 2'b10 (code fault, data intact), and no RAM write occurs.
- R5: Every other non-zero syndrome gives status 2'b11, and no RAM write occurs.
- R6: If a request is accepted at clock edge k, then `in_ready` is low after edge k. `res_valid` is high for exactly the one cycle that follows edge k+1.
- R7: When `fix_en` was high at acceptance and the status is 2'b01, the block acts in two cycles:
  - In the `res_valid` cycle it asserts `ram_re` with `ram_addr` equal to the byte index.
  - In the next cycle it asserts `ram_we` to the same address, with `ram_wdata` equal to the read byte XOR the mask.
  - `in_ready` stays low until that write cycle ends.
- R8: When `fix_en` was low at acceptance, the RAM is neither read nor written, even for status 2'b01.
- R9: While reset is held, `in_ready` is high and `res_valid`, `ram_re` and `ram_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| stored_ecc | input | 24 | Code read from the spare area |
| calc_ecc | input | 24 | Code computed over the data read |
| fix_en | input | 1 | Repair the RAM byte on a correctable error |
| res_valid | output | 1 | One-cycle result strobe |
| res_status | output | 2 | 00 clean, 01 corrected, 10 code-only fault, 11 uncorrectable |
| res_byte_idx | output | 9 | Faulty byte index (status 01 only) |
| res_bit_mask | output | 8 | One-hot flip mask (status 01 only) |
| ram_re | output | 1 | Data RAM read strobe |
| ram_we | output | 1 | Data RAM write strobe |
| ram_addr | output | 9 | Data RAM byte address |
| ram_wdata | output | 8 | Repaired byte |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |

## Verification
The bench aims at syndromes that look correctable but come from an all-ones stored code. A design that tested the syndrome before the blank-page check would write a flip into a page that was never coded. It also covers single-bit syndromes at both ends of the 24-bit code and in the middle, plus a 12-bit pattern broken in one pair. A design that confused the two non-data outcomes would report uncorrectable or corrected for these.

Correctable patterns use the extreme byte indices 0 and 511 and mixed ones, with bit 0 and bit 7. Any swap in the irregular index mapping therefore shows up as a wrong address in the RAM image. Back-to-back requests held against a low `in_ready` expose a design that accepts a request during its write-back cycle.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ECC_BYTES = 3;
  localparam int unsigned SYN_W     = BYTE_W * ECC_BYTES;
  localparam int unsigned PAIRS     = BYTE_W / 2;
  localparam int unsigned ODD_W     = ECC_BYTES * PAIRS;
  localparam int unsigned BIDX_W    = 9;
  localparam int unsigned BITX_W    = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXED    = 2'b01,
    ST_ECC_ONLY = 2'b10,
    ST_BAD      = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/nand_ecc_locate.sv
// Pair test and index extraction. The odd bits of the syndrome, taken in
// ascending order, form {bit index, byte index}.
module nand_ecc_locate
  import nand_ecc_pkg::*;
(
  input  logic [SYN_W-1:0]  syn,
  output logic              correctable,
  output logic [BIDX_W-1:0] byte_idx,
  output logic [BITX_W-1:0] bit_idx
);
  logic [ODD_W-1:0] odd_bits;
  logic [ODD_W-1:0] pair_diff;

  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_byte
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign odd_bits[g*PAIRS+p]  = syn[g*BYTE_W+2*p+1];
      assign pair_diff[g*PAIRS+p] = syn[g*BYTE_W+2*p+1] ^ syn[g*BYTE_W+2*p];
    end
  end

  assign correctable = &pair_diff;
  assign byte_idx    = odd_bits[BIDX_W-1:0];
  assign bit_idx     = odd_bits[BIDX_W +: BITX_W];
endmodule

// File: rtl/nand_ecc_classify.sv
// Builds the syndrome and sorts it into one of the four outcomes.
module nand_ecc_classify
  import nand_ecc_pkg::*;
(
  input  logic [SYN_W-1:0] stored,
  input  logic [SYN_W-1:0] calc,
  input  logic             correctable,
  output logic [SYN_W-1:0] syn,
  output ecc_status_e      status
);
  logic [ECC_BYTES-1:0] byte_blank;
  logic                 page_blank;
  logic                 syn_zero;
  logic                 syn_single;

  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_blank
    assign byte_blank[g] = &stored[g*BYTE_W +: BYTE_W];
  end

  assign syn        = stored ^ calc;
  assign page_blank = &byte_blank;
  assign syn_zero   = (syn == '0);
  assign syn_single = !syn_zero && ((syn & (syn - SYN_W'(1))) == '0);

  always_comb begin
    if (syn_zero || page_blank) status = ST_CLEAN;
    else if (correctable)       status = ST_FIXED;
    else if (syn_single)        status = ST_ECC_ONLY;
    else                        status = ST_BAD;
  end
endmodule

// File: rtl/nand_ecc_rmw.sv
// Two-cycle read-modify-write of one RAM byte.
module nand_ecc_rmw #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] mask,
  output logic          busy,
  output logic          ram_re,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  typedef enum logic [1:0] {R_IDLE, R_READ, R_WRITE} rmw_state_e;

  rmw_state_e    state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= R_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      unique case (state)
        R_IDLE: if (start) begin
          state  <= R_READ;
          addr_q <= addr;
          mask_q <= mask;
        end
        R_READ:  state <= R_WRITE;
        default: state <= R_IDLE;
      endcase
    end
  end

  assign busy      = (state != R_IDLE);
  assign ram_re    = (state == R_READ);
  assign ram_we    = (state == R_WRITE);
  assign ram_addr  = addr_q;
  assign ram_wdata = ram_rdata ^ mask_q;
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SYN_W-1:0]  stored_ecc,
  input  logic [SYN_W-1:0]  calc_ecc,
  input  logic              fix_en,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [BIDX_W-1:0] res_byte_idx,
  output logic [BYTE_W-1:0] res_bit_mask,
  output logic              ram_re,
  output logic              ram_we,
  output logic [BIDX_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata
);
  typedef enum logic {S_IDLE, S_EVAL} top_state_e;

  top_state_e        state;
  logic [SYN_W-1:0]  stored_q, calc_q;
  logic              fix_q;
  logic [SYN_W-1:0]  syn;
  logic              correctable;
  logic [BIDX_W-1:0] byte_idx;
  logic [BITX_W-1:0] bit_idx;
  logic [BYTE_W-1:0] flip_mask;
  ecc_status_e       status;
  logic              rmw_start, rmw_busy;
  logic              accept;

  nand_ecc_locate u_locate (
    .syn(syn), .correctable(correctable), .byte_idx(byte_idx), .bit_idx(bit_idx)
  );

  nand_ecc_classify u_classify (
    .stored(stored_q), .calc(calc_q), .correctable(correctable),
    .syn(syn), .status(status)
  );

  for (genvar b = 0; b < BYTE_W; b++) begin : g_mask
    assign flip_mask[b] = (bit_idx == BITX_W'(b));
  end

  assign in_ready  = (state == S_IDLE) && !res_valid && !rmw_busy;
  assign accept    = in_valid && in_ready;
  assign rmw_start = (state == S_EVAL) && fix_q && (status == ST_FIXED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      stored_q     <= '0;
      calc_q       <= '0;
      fix_q        <= 1'b0;
      res_valid    <= 1'b0;
      res_status   <= ST_CLEAN;
      res_byte_idx <= '0;
      res_bit_mask <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          stored_q <= stored_ecc;
          calc_q   <= calc_ecc;
          fix_q    <= fix_en;
          state    <= S_EVAL;
        end
        default: begin
          res_valid    <= 1'b1;
          res_status   <= status;
          res_byte_idx <= (status == ST_FIXED) ? byte_idx : '0;
          res_bit_mask <= (status == ST_FIXED) ? flip_mask : '0;
          state        <= S_IDLE;
        end
      endcase
    end
  end

  nand_ecc_rmw #(.AW(BIDX_W), .DW(BYTE_W)) u_rmw (
    .clk(clk), .rst_n(rst_n), .start(rmw_start),
    .addr(byte_idx), .mask(flip_mask), .busy(rmw_busy),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );
endmodule

// File: rtl/nand_ecc_fixer_chk.sv
module nand_ecc_fixer_chk
  import nand_ecc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic [1:0]        res_status,
  input logic [BIDX_W-1:0] res_byte_idx,
  input logic [BYTE_W-1:0] res_bit_mask,
  input logic              ram_re,
  input logic              ram_we,
  input logic [BIDX_W-1:0] ram_addr
);
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_result_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 res_valid);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_zero_loc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'b01) |-> (res_byte_idx == '0 && res_bit_mask == '0));
  p_onehot_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'b01) |-> ($countones(res_bit_mask) == 1));
  p_read_with_fix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> (res_valid && res_status == 2'b01 && ram_addr == res_byte_idx));
  p_write_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> (ram_we && ram_addr == $past(ram_addr)));
  p_write_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(ram_re));
  p_no_ram_non_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'b01) |-> (!ram_re && !ram_we));
  p_write_blocks_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !in_ready);
endmodule

bind nand_ecc_fixer nand_ecc_fixer_chk u_chk (.*);

// File: tb/sim_nand_ecc_fixer.sv
module sim_nand_ecc_fixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] stored_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic        fix_en = 1'b0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [8:0]  res_byte_idx;
  logic [7:0]  res_bit_mask;
  logic        ram_re, ram_we;
  logic [8:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  always #10 clk = ~clk;

  nand_ecc_fixer u0 (.*);

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] mem [512];
  logic [7:0] gold [512];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (ram_we) mem[ram_addr] <= ram_wdata;
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference of the requirements
  function automatic int ref_eval(input logic [23:0] s, input logic [23:0] c,
                                  output int idx, output int bitn);
    logic [23:0] d = s ^ c;
    bit ok = 1;
    idx = 0; bitn = 0;
    if (d == 0) return 0;
    if (s == 24'hFFFFFF) return 0;
    for (int i = 0; i < 12; i++) if (d[2*i] == d[2*i+1]) ok = 0;
    if (ok) begin
      idx = d[1] + 2*d[3] + 4*d[5] + 8*d[7] + 16*d[9] + 32*d[11]
          + 64*d[13] + 128*d[15] + 256*d[17];
      bitn = d[19] + 2*d[21] + 4*d[23];
      return 1;
    end
    if ($countones(d) == 1) return 2;
    return 3;
  endfunction

  function automatic logic [23:0] mk_syn(int byte_i, int bit_i);
    logic [11:0] v = {3'(bit_i), 9'(byte_i)};
    logic [23:0] r;
    for (int i = 0; i < 12; i++) begin
      r[2*i+1] = v[i];
      r[2*i]   = ~v[i];
    end
    return r;
  endfunction

  // model state: 0 idle, 1 eval, 2 result+read, 4 result only, 3 write
  int ph = 0, m_st = 0, m_idx = 0, m_bit = 0;
  logic [7:0] m_mask = '0;
  logic [23:0] ls = '0, lc = '0;
  bit lf = 0;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else begin
      case (ph)
        0: if (in_valid) begin ls = stored_ecc; lc = calc_ecc; lf = fix_en; ph = 1; end
        1: begin
          m_st   = ref_eval(ls, lc, m_idx, m_bit);
          m_mask = (m_st == 1) ? 8'(1 << m_bit) : 8'h00;
          ph     = (lf && m_st == 1) ? 2 : 4;
        end
        2: ph = 3;
        3: begin gold[m_idx] = gold[m_idx] ^ m_mask; ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  function automatic string st_tag();
    if (ls == 24'hFFFFFF) return "R2";
    case (m_st) 0: return "R1"; 1: return "R3"; 2: return "R4"; default: return "R5"; endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == (ph == 0), "R6", "in_ready", in_ready, ph == 0);
      chk(res_valid == (ph == 2 || ph == 4), "R6", "res_valid", res_valid, ph == 2 || ph == 4);
      if (ph == 2 || ph == 4) begin
        chk(res_status == 2'(m_st), st_tag(), "status", res_status, m_st);
        chk(res_byte_idx == 9'(m_idx), st_tag(), "byte_idx", res_byte_idx, m_idx);
        chk(res_bit_mask == m_mask, st_tag(), "bit_mask", res_bit_mask, m_mask);
      end
      chk(ram_re == (ph == 2), lf ? "R7" : "R8", "ram_re", ram_re, ph == 2);
      chk(ram_we == (ph == 3), lf ? "R7" : "R8", "ram_we", ram_we, ph == 3);
      if (ph == 2 || ph == 3)
        chk(ram_addr == 9'(m_idx), "R7", "ram_addr", ram_addr, m_idx);
      if (ph == 3)
        chk(ram_wdata == (gold[m_idx] ^ m_mask), "R7", "ram_wdata", ram_wdata,
            gold[m_idx] ^ m_mask);
    end
  end

  task automatic send(input logic [23:0] s, input logic [23:0] c, input bit f);
    bit acc;
    stored_ecc = s; calc_ecc = c; fix_en = f; in_valid = 1'b1;
    forever begin
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = init_val(i); gold[i] = init_val(i); end
    repeat (3) @(negedge clk);
    // R9: state during reset
    chk(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);
    chk(res_valid == 1'b0, "R9", "res_valid", res_valid, 0);
    chk(ram_re == 1'b0 && ram_we == 1'b0, "R9", "ram strobes", {ram_re, ram_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(24'h5A3C81, 24'h5A3C81, 1);                        // R1 clean
    send(24'hFFFFFF, 24'h123456, 1);                        // R2 blank page
    send(24'hFFFFFF, 24'hFFFFFF ^ mk_syn(3, 2), 1);         // R2 blank, correctable-looking
    send(24'h00A5C3, 24'h00A5C3 ^ mk_syn(0, 0), 1);         // R3 R7 byte 0 bit 0
    send(24'h13579B, 24'h13579B ^ mk_syn(511, 7), 1);       // R3 R7 byte 511 bit 7
    send(24'h2468AC, 24'h2468AC ^ mk_syn(341, 5), 0);       // R8 no repair
    send(24'h777777, 24'h777777 ^ mk_syn(200, 3), 1);       // R3 R7
    send(24'h0F0F0F, 24'h0F0F0E, 1);                        // R4 bit 0
    send(24'h0F0F0F, 24'h8F0F0F, 1);                        // R4 bit 23
    send(24'h0F0F0F, 24'h0F1F0F, 1);                        // R4 bit 12
    send(24'h010203, 24'h010203 ^ mk_syn(10, 1) ^ 24'h10, 1); // R5 broken pair
    send(24'h010203, 24'h010203 ^ 24'h000300, 1);           // R5 two bits
    send(24'h0000F0, 24'hFFFF0F, 1);                        // R5 all-ones syndrome
    for (int k = 0; k < 6; k++)                             // back-to-back R6 R7
      send(24'h300000 + 24'(k), (24'h300000 + 24'(k)) ^ mk_syn(k * 85 + 3, k), k[0]);
    repeat (6) @(negedge clk);

    chk(mem[0] == (init_val(0) ^ 8'h01), "R7", "mem[0]", mem[0], init_val(0) ^ 8'h01);
    chk(mem[511] == (init_val(511) ^ 8'h80), "R7", "mem[511]", mem[511], init_val(511) ^ 8'h80);
    chk(mem[341] == init_val(341), "R8", "mem[341]", mem[341], init_val(341));
    for (int i = 0; i < 512; i++)
      chk(mem[i] == gold[i], "R7", "ram image", mem[i], gold[i]);
    finish_run();
  end
endmodule